// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a 16-bit data bus and a 3-bit direct address reach a much larger internal space of per-channel control registers and per-channel coefficient and instruction RAMs. The host never addresses a target directly. To write, it stages a 32-bit word in two 16-bit halves and then writes the internal target address to a trigger port. The bridge then issues a one-cycle internal write strobe. To read, it writes the internal address to a second trigger port, waits for the fetch to finish, and collects the word from the two half addresses.

Each trigger opens a fixed busy window. A trigger that arrives inside that window is refused and recorded. A separate direct read address pops 16-bit words from an output FIFO. The FIFO itself sits outside the block. A host access to a channel's RAMs is honoured only while that channel's hold bit is set; otherwise it is dropped and recorded. A write to a dedicated per-channel offset starts a timed software reset of that channel. The register file and the RAMs are behavioural stand-ins for the real targets.

Top module: `ib_top`

## Requirements
- R1: A host write to direct address 0 loads bits 15:0 of the write holding word and a write to address 1 loads bits 31:16. Channel registers at offsets 0x000–0x00F keep all 32 bits. Registers at offsets 0x010–0x018 keep only bits 15:0 and read bits 31:16 as zero.
- R2: A host write to direct address 2 takes the data as an internal address. It raises an internal write strobe for exactly one cycle, the cycle after the trigger, and the holding word is stored into that target at the end of that cycle.
- R3: From the clock edge that accepts a trigger at address 2 or 3, busy_o is high for exactly 4 cycles.
- R4: A host write to direct address 3 takes the data as an internal address. The fetched word is then presented on host_rdata_o while host_addr_i is 0 (bits 15:0) or 1 (bits 31:16).
- R5: rd_valid_o falls on the edge that accepts a read trigger and rises 4 cycles later, when the fetched word is in place.
- R6: While host_addr_i is 2, host_rdata_o shows fifo_data_i. A host read at address 2 raises fifo_pop_o, so one word is consumed per read cycle.
- R7: Internal address bits 15:12 give the channel (0–3) and bits 11:0 the offset. Coefficient RAM word i is at offset 0x100+i and instruction RAM word i at offset 0x200+i (i < 16). Bit 31 of the register at offset 0x00A is the channel's hold bit and appears on hold_o.
- R8: A write or read of a channel RAM while that channel's hold bit is clear has no effect on the RAM. Such a read returns zero. Either access sets the sticky flag err_hold_o.
- R9: A write to channel offset 0x019 drives that channel's chan_rst_o bit high for exactly 32 cycles. The offset reads as zero.
- R10: A trigger at address 2 or 3 while busy_o is high is ignored and sets the sticky flag err_ovr_o.
- R11: An address that decodes to nothing reads as zero, and a write to it changes no target. This covers channel digits 4–15, register offsets 0x01A–0x0FF and RAM indices past the depth.
- R12: rst_ni low clears the holding words, all channel registers (and so all hold bits), busy_o, rd_valid_o, chan_rst_o and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | 3 | Direct host address |
| host_wdata_i | input | 16 | Host write data |
| host_wr_i | input | 1 | Host write enable |
| host_rd_i | input | 1 | Host read enable |
| host_rdata_o | output | 16 | Host read data |
| fifo_data_i | input | 16 | Head word of the output FIFO |
| fifo_pop_o | output | 1 | Consume the FIFO head word |
| busy_o | output | 1 | Indirect access in progress |
| rd_valid_o | output | 1 | Fetched read word is valid |
| err_ovr_o | output | 1 | Sticky: trigger refused while busy |
| err_hold_o | output | 1 | Sticky: RAM access without hold |
| hold_o | output | 4 | Per-channel hold bits |
| chan_rst_o | output | 4 | Per-channel software reset active |

## Verification
A FIFO pop and an internal register commit can fall in the same cycle. The host's trigger write at address 2 leaves the address bus at 2, so a read in the next cycle pops the FIFO while the write strobe stores the holding word. The bench provokes this on purpose. It issues one trigger and then keeps host_rd_i high for the trigger cycle and the strobe cycle. It judges the result two ways: the FIFO head must have advanced by exactly two words, and a later indirect read of the target must return the staged word.

// File: rtl/ib_pkg.sv
package ib_pkg;
  typedef enum logic [1:0] {K_NONE, K_REG, K_COEF, K_INSTR} kind_e;
endpackage

// File: rtl/ib_decode.sv
module ib_decode import ib_pkg::*; #(
  parameter int AW          = 16,
  parameter int NUM_CH      = 4,
  parameter int REG_CNT     = 26,
  parameter int COEF_DEPTH  = 16,
  parameter int INSTR_DEPTH = 16,
  parameter int COEF_PAGE   = 1,
  parameter int INSTR_PAGE  = 2,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [AW-1:0]   addr_i,
  output kind_e           kind_o,
  output logic [CH_W-1:0] chan_o,
  output logic [7:0]      idx_o
);
  always_comb begin
    kind_o = K_NONE;
    chan_o = addr_i[AW-4 +: CH_W];
    idx_o  = addr_i[7:0];
    if ({28'd0, addr_i[AW-1 -: 4]} < NUM_CH) begin
      if ({20'd0, addr_i[11:0]} < REG_CNT)
        kind_o = K_REG;
      else if (addr_i[11:8] == 4'(COEF_PAGE) && {24'd0, addr_i[7:0]} < COEF_DEPTH)
        kind_o = K_COEF;
      else if (addr_i[11:8] == 4'(INSTR_PAGE) && {24'd0, addr_i[7:0]} < INSTR_DEPTH)
        kind_o = K_INSTR;
    end
  end
endmodule

// File: rtl/ib_seq.sv
module ib_seq #(
  parameter int AW  = 16,
  parameter int LAT = 4,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_w_i,
  input  logic          trig_r_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          wr_stb_o,
  output logic          rd_cap_o,
  output logic [AW-1:0] addr_o,
  output logic          err_ovr_o
);
  logic [CW-1:0] cnt_q;
  logic          rd_q, stb_q, ovr_q;
  logic [AW-1:0] addr_q;
  logic          trig, accept;

  assign trig   = trig_w_i | trig_r_i;
  assign accept = trig && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      stb_q  <= 1'b0;
      ovr_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      stb_q <= accept && trig_w_i;
      if (accept) begin
        cnt_q  <= CW'(LAT);
        addr_q <= addr_i;
        rd_q   <= trig_r_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (trig && cnt_q != '0) ovr_q <= 1'b1;
    end
  end

  assign busy_o    = cnt_q != '0;
  assign wr_stb_o  = stb_q;
  assign rd_cap_o  = rd_q && (cnt_q == CW'(1));  // fetch lands on last busy edge
  assign addr_o    = addr_q;
  assign err_ovr_o = ovr_q;
endmodule

// File: rtl/ib_targets.sv
module ib_targets import ib_pkg::*; #(
  parameter int DW          = 16,
  parameter int NUM_CH      = 4,
  parameter int REG_CNT     = 26,
  parameter int WIDE_REGS   = 16,
  parameter int HOLD_OFF    = 10,
  parameter int HOLD_BIT    = 31,
  parameter int CRST_OFF    = 25,
  parameter int CRST_CYC    = 32,
  parameter int COEF_DEPTH  = 16,
  parameter int INSTR_DEPTH = 16,
  localparam int TW   = 2 * DW,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RIW  = $clog2(REG_CNT),
  localparam int CIW  = $clog2(COEF_DEPTH),
  localparam int IIW  = $clog2(INSTR_DEPTH),
  localparam int RCW  = $clog2(CRST_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  kind_e             kind_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [7:0]        idx_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [TW-1:0]     wdata_i,
  output logic [TW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] hold_o,
  output logic [NUM_CH-1:0] chan_rst_o,
  output logic              err_hold_o
);
  logic [TW-1:0] ch_rd [NUM_CH];
  logic          eh_q;
  logic          is_ram;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [TW-1:0]  regs_q [REG_CNT];
    logic [TW-1:0]  coef_q [COEF_DEPTH];
    logic [TW-1:0]  ins_q  [INSTR_DEPTH];
    logic [RCW-1:0] rc_q;
    logic           sel, reg_we, crst_hit;
    logic [RIW-1:0] ri;
    logic [CIW-1:0] ci;
    logic [IIW-1:0] ii;

    assign sel      = chan_i == CH_W'(c);
    assign ri       = idx_i[RIW-1:0];
    assign ci       = idx_i[CIW-1:0];
    assign ii       = idx_i[IIW-1:0];
    assign crst_hit = we_i && sel && kind_i == K_REG && ri == RIW'(CRST_OFF);
    assign reg_we   = we_i && sel && kind_i == K_REG && ri != RIW'(CRST_OFF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < REG_CNT; i++) regs_q[i] <= '0;
        rc_q <= '0;
      end else begin
        if (reg_we)
          regs_q[ri] <= ({24'd0, idx_i} < WIDE_REGS) ? wdata_i : {{DW{1'b0}}, wdata_i[DW-1:0]};
        if (crst_hit)         rc_q <= RCW'(CRST_CYC);
        else if (rc_q != '0)  rc_q <= rc_q - 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (we_i && sel && hold_o[c] && kind_i == K_COEF)  coef_q[ci] <= wdata_i;
      if (we_i && sel && hold_o[c] && kind_i == K_INSTR) ins_q[ii]  <= wdata_i;
    end

    assign hold_o[c]     = regs_q[HOLD_OFF][HOLD_BIT];
    assign chan_rst_o[c] = rc_q != '0;

    always_comb begin
      case (kind_i)
        K_REG:   ch_rd[c] = regs_q[ri];
        K_COEF:  ch_rd[c] = hold_o[c] ? coef_q[ci] : '0;
        K_INSTR: ch_rd[c] = hold_o[c] ? ins_q[ii]  : '0;
        default: ch_rd[c] = '0;
      endcase
    end
  end

  assign is_ram  = kind_i == K_COEF || kind_i == K_INSTR;
  assign rdata_o = (kind_i == K_NONE) ? '0 : ch_rd[chan_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          eh_q <= 1'b0;
    else if ((we_i || re_i) && is_ram && !hold_o[chan_i]) eh_q <= 1'b1;
  end
  assign err_hold_o = eh_q;
endmodule

// File: rtl/ib_top.sv
module ib_top import ib_pkg::*; #(
  parameter int DW          = 16,
  parameter int NUM_CH      = 4,
  parameter int REG_CNT     = 26,
  parameter int WIDE_REGS   = 16,
  parameter int HOLD_OFF    = 10,
  parameter int HOLD_BIT    = 31,
  parameter int CRST_OFF    = 25,
  parameter int CRST_CYC    = 32,
  parameter int COEF_DEPTH  = 16,
  parameter int INSTR_DEPTH = 16,
  parameter int LAT         = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  output logic [DW-1:0]     host_rdata_o,
  input  logic [DW-1:0]     fifo_data_i,
  output logic              fifo_pop_o,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic              err_ovr_o,
  output logic              err_hold_o,
  output logic [NUM_CH-1:0] hold_o,
  output logic [NUM_CH-1:0] chan_rst_o
);
  localparam int TW   = 2 * DW;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [TW-1:0]   whold_q, rhold_q, t_rdata;
  logic            rvalid_q, wr_stb, rd_cap, trig_w, trig_r;
  logic [DW-1:0]   t_addr;
  kind_e           t_kind;
  logic [CH_W-1:0] t_chan;
  logic [7:0]      t_idx;

  assign trig_w = host_wr_i && host_addr_i == 3'd2;
  assign trig_r = host_wr_i && host_addr_i == 3'd3;

  ib_seq #(.AW(DW), .LAT(LAT)) u_seq (
    .clk_i, .rst_ni,
    .trig_w_i (trig_w),
    .trig_r_i (trig_r),
    .addr_i   (host_wdata_i),
    .busy_o,
    .wr_stb_o (wr_stb),
    .rd_cap_o (rd_cap),
    .addr_o   (t_addr),
    .err_ovr_o
  );

  ib_decode #(
    .AW(DW), .NUM_CH(NUM_CH), .REG_CNT(REG_CNT),
    .COEF_DEPTH(COEF_DEPTH), .INSTR_DEPTH(INSTR_DEPTH)
  ) u_dec (
    .addr_i (t_addr),
    .kind_o (t_kind),
    .chan_o (t_chan),
    .idx_o  (t_idx)
  );

  ib_targets #(
    .DW(DW), .NUM_CH(NUM_CH), .REG_CNT(REG_CNT), .WIDE_REGS(WIDE_REGS),
    .HOLD_OFF(HOLD_OFF), .HOLD_BIT(HOLD_BIT), .CRST_OFF(CRST_OFF),
    .CRST_CYC(CRST_CYC), .COEF_DEPTH(COEF_DEPTH), .INSTR_DEPTH(INSTR_DEPTH)
  ) u_tgt (
    .clk_i, .rst_ni,
    .kind_i  (t_kind),
    .chan_i  (t_chan),
    .idx_i   (t_idx),
    .we_i    (wr_stb),
    .re_i    (rd_cap),
    .wdata_i (whold_q),
    .rdata_o (t_rdata),
    .hold_o,
    .chan_rst_o,
    .err_hold_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      whold_q  <= '0;
      rhold_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (host_wr_i && host_addr_i == 3'd0) whold_q[DW-1:0]  <= host_wdata_i;
      if (host_wr_i && host_addr_i == 3'd1) whold_q[TW-1:DW] <= host_wdata_i;
      if (rd_cap) begin
        rhold_q  <= t_rdata;
        rvalid_q <= 1'b1;
      end else if (trig_r && !busy_o) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (host_addr_i)
      3'd0:    host_rdata_o = rhold_q[DW-1:0];
      3'd1:    host_rdata_o = rhold_q[TW-1:DW];
      3'd2:    host_rdata_o = fifo_data_i;
      default: host_rdata_o = '0;
    endcase
  end

  assign fifo_pop_o = host_rd_i && host_addr_i == 3'd2;
  assign rd_valid_o = rvalid_q;
endmodule

// File: rtl/ib_checker.sv
module ib_checker #(
  parameter int LAT = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_wr_i,
  input logic [2:0] host_addr_i,
  input logic       busy_o,
  input logic       rd_valid_o,
  input logic       wr_stb,
  input logic       err_ovr_o,
  input logic       err_hold_o
);
  logic       trig;
  logic [7:0] run_q;

  assign trig = host_wr_i && host_addr_i[2:1] == 2'b01;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  AST_BUSY_ON_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && !busy_o) |=> busy_o);  // R3
  AST_BUSY_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < 8'(LAT));  // R3
  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> !wr_stb);  // R2
  AST_STB_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |-> $past(host_wr_i && host_addr_i == 3'd2 && !busy_o));  // R2
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == 3'd3 && !busy_o) |=> !rd_valid_o);  // R5
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && busy_o) |=> err_ovr_o);  // R10
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ovr_o |=> err_ovr_o);  // R10
  AST_HOLD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hold_o |=> err_hold_o);  // R8
endmodule

bind ib_top ib_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_wr_i   (host_wr_i),
  .host_addr_i (host_addr_i),
  .busy_o      (busy_o),
  .rd_valid_o  (rd_valid_o),
  .wr_stb      (wr_stb),
  .err_ovr_o   (err_ovr_o),
  .err_hold_o  (err_hold_o)
);

// File: tb/ib_top_bench.sv
module ib_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] rdata, fifo_data;
  logic        fifo_pop, busy, rd_valid, err_ovr, err_hold;
  logic [3:0]  hold, chan_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_reg  [4][26];
  logic [31:0] exp_coef [4][16];
  logic [31:0] exp_ins  [4][16];
  logic        exp_eh = 1'b0;
  logic [15:0] fifo_ptr = '0;
  logic [15:0] exp_ptr = '0;

  always #4 clk = ~clk;

  ib_top u_ib_top (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_wr_i(wr), .host_rd_i(rd), .host_rdata_o(rdata), .fifo_data_i(fifo_data),
    .fifo_pop_o(fifo_pop), .busy_o(busy), .rd_valid_o(rd_valid), .err_ovr_o(err_ovr),
    .err_hold_o(err_hold), .hold_o(hold), .chan_rst_o(chan_rst)
  );

  function automatic logic [15:0] fifo_word(input logic [15:0] p);
    return {p[7:0], ~p[7:0]} ^ 16'h3C00;
  endfunction
  assign fifo_data = fifo_word(fifo_ptr);
  always @(posedge clk) if (fifo_pop) fifo_ptr <= fifo_ptr + 16'd1;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // 0 none, 1 register, 2 coefficient RAM, 3 instruction RAM
  function automatic int kind_of(input logic [15:0] ia);
    if (ia[15:12] > 4'd3) return 0;
    if (ia[11:0] < 12'd26) return 1;
    if (ia[11:8] == 4'h1 && ia[7:0] < 8'd16) return 2;
    if (ia[11:8] == 4'h2 && ia[7:0] < 8'd16) return 3;
    return 0;
  endfunction

  function automatic logic m_hold(input int c);
    return exp_reg[c][10][31];
  endfunction

  function automatic logic [3:0] m_holds();
    logic [3:0] h;
    for (int c = 0; c < 4; c++) h[c] = m_hold(c);
    return h;
  endfunction

  task automatic m_write(input logic [15:0] ia, input logic [31:0] d);
    int c = int'(ia[13:12]);
    int i = int'(ia[7:0]);
    case (kind_of(ia))
      1: if (i != 25) exp_reg[c][i] = (i < 16) ? d : {16'd0, d[15:0]};
      2: if (m_hold(c)) exp_coef[c][i] = d; else exp_eh = 1'b1;
      3: if (m_hold(c)) exp_ins[c][i] = d; else exp_eh = 1'b1;
      default: ;
    endcase
  endtask

  task automatic m_read(input logic [15:0] ia, output logic [31:0] d);
    int c = int'(ia[13:12]);
    int i = int'(ia[7:0]);
    d = '0;
    case (kind_of(ia))
      1: d = exp_reg[c][i];
      2: if (m_hold(c)) d = exp_coef[c][i]; else exp_eh = 1'b1;
      3: if (m_hold(c)) d = exp_ins[c][i]; else exp_eh = 1'b1;
      default: ;
    endcase
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic ind_write(input logic [15:0] ia, input logic [31:0] d);
    bus_wr(3'd0, d[15:0]);
    bus_wr(3'd1, d[31:16]);
    bus_wr(3'd2, ia);
    repeat (3) @(negedge clk);
    m_write(ia, d);
  endtask

  task automatic ind_read(input logic [15:0] ia, output logic [31:0] d);
    bus_wr(3'd3, ia);
    repeat (4) @(negedge clk);
    addr = 3'd0; #1 d[15:0] = rdata;
    addr = 3'd1; #1 d[31:16] = rdata;
  endtask

  task automatic rd_cmp(input string req, input logic [15:0] ia);
    logic [31:0] got, exp;
    ind_read(ia, got);
    m_read(ia, exp);
    chk(req, $sformatf("readback @%h", ia), got, exp);
  endtask

  task automatic clear_model();
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 26; i++) exp_reg[c][i] = '0;
    exp_eh = 1'b0;
  endtask

  function automatic logic [15:0] rand_addr();
    int s = int'($urandom % 8);
    logic [15:0] c = 16'($urandom % 4) << 12;
    case (s)
      0, 1, 2, 3: return c | 16'($urandom % 25);
      4: return c | 16'h0100 | 16'($urandom % 16);
      5: return c | 16'h0200 | 16'($urandom % 16);
      6: return ($urandom % 2 == 0) ? (16'(4 + $urandom % 12) << 12) : (c | 16'h0300);
      default: return c | 16'h000A;
    endcase
  endfunction

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'h5EED1234));
    clear_model();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "busy after reset", 32'(busy), 0);
    chk("R12", "rd_valid after reset", 32'(rd_valid), 0);
    chk("R12", "err_ovr after reset", 32'(err_ovr), 0);
    chk("R12", "err_hold after reset", 32'(err_hold), 0);
    chk("R12", "hold after reset", 32'(hold), 0);
    chk("R12", "chan_rst after reset", 32'(chan_rst), 0);
    rst_n = 1'b1;

    // R7 fill all RAMs under hold
    for (int c = 0; c < 4; c++) begin
      ind_write(16'(c << 12) | 16'h000A, 32'h8000_0000);
      for (int i = 0; i < 16; i++) begin
        ind_write(16'(c << 12) | 16'h0100 | 16'(i), $urandom);
        ind_write(16'(c << 12) | 16'h0200 | 16'(i), $urandom);
      end
    end
    chk("R7", "hold bits after setting", 32'(hold), 32'hF);

    // R3 busy window, R2 commit, R1 32-bit register
    bus_wr(3'd0, 16'h1234);
    bus_wr(3'd1, 16'hABCD);
    bus_wr(3'd2, 16'h0003);
    chk("R3", "busy cycle 1", 32'(busy), 1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk("R3", $sformatf("busy cycle %0d", k), 32'(busy), 1);
    end
    @(negedge clk);
    chk("R3", "busy dropped after 4", 32'(busy), 0);
    m_write(16'h0003, 32'hABCD_1234);
    rd_cmp("R2", 16'h0003);

    // R5 read latency, R4 halves
    bus_wr(3'd3, 16'h0003);
    chk("R5", "rd_valid low at accept", 32'(rd_valid), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5", "rd_valid low in window", 32'(rd_valid), 0);
    end
    @(negedge clk);
    chk("R5", "rd_valid after 4", 32'(rd_valid), 1);
    addr = 3'd0; #1 chk("R4", "low half", 32'(rdata), 32'h1234);
    addr = 3'd1; #1 chk("R4", "high half", 32'(rdata), 32'hABCD);

    // R1 narrow register drops upper half
    ind_write(16'h3012, 32'hFFFF_5A5A);
    ind_read(16'h3012, d);
    chk("R1", "narrow register", d, 32'h0000_5A5A);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [15:0] ia = rand_addr();
      if ($urandom % 2 == 0) ind_write(ia, $urandom);
      else rd_cmp("R11", ia);
      chk("R8", "err_hold tracks model", 32'(err_hold), 32'(exp_eh));
      chk("R7", "hold bits track model", 32'(hold), 32'(m_holds()));
    end

    // R10 overrun
    clear_model();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R10", "err_ovr clear", 32'(err_ovr), 0);
    ind_write(16'h0005, 32'h0000_5555);
    bus_wr(3'd0, 16'h7777);
    bus_wr(3'd1, 16'h6666);
    bus_wr(3'd2, 16'h0004);
    bus_wr(3'd2, 16'h0005);
    chk("R10", "err_ovr set", 32'(err_ovr), 1);
    repeat (3) @(negedge clk);
    m_write(16'h0004, 32'h6666_7777);
    rd_cmp("R10", 16'h0005);
    rd_cmp("R10", 16'h0004);
    chk("R10", "err_ovr sticky", 32'(err_ovr), 1);

    // R6 FIFO pops
    exp_ptr = fifo_ptr;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      addr = 3'd2; rd = 1'b1;
      #1 chk("R6", "fifo word", 32'(rdata), 32'(fifo_word(exp_ptr)));
      chk("R6", "pop strobe", 32'(fifo_pop), 1);
      exp_ptr++;
    end
    @(negedge clk); rd = 1'b0;
    // pop in the trigger cycle and in the commit-strobe cycle
    bus_wr(3'd0, 16'hC0DE);
    bus_wr(3'd1, 16'h0BEE);
    @(negedge clk); addr = 3'd2; wdata = 16'h0006; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk); rd = 1'b0;
    #1 chk("R6", "two pops across commit", 32'(rdata), 32'(fifo_word(exp_ptr + 16'd2)));
    repeat (2) @(negedge clk);
    m_write(16'h0006, 32'h0BEE_C0DE);
    rd_cmp("R2", 16'h0006);

    // R12 reset during a busy window
    ind_write(16'h000A, 32'h8000_0000);
    ind_write(16'h0001, 32'hDEAD_BEEF);
    bus_wr(3'd0, 16'h1111);
    bus_wr(3'd2, 16'h0002);
    rst_n = 1'b0; #1;
    chk("R12", "busy cleared", 32'(busy), 0);
    chk("R12", "err_ovr cleared", 32'(err_ovr), 0);
    chk("R12", "hold cleared", 32'(hold), 0);
    chk("R12", "rd_valid cleared", 32'(rd_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    clear_model();
    rd_cmp("R12", 16'h0001);
    rd_cmp("R12", 16'h0002);
    bus_wr(3'd3, 16'h0FFF);
    bus_wr(3'd2, 16'h0001);  // overrun: holding word must read back zero later
    repeat (3) @(negedge clk);
    clear_model();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    ind_write(16'h0001, 32'h0);
    ind_write(16'h0002, {16'h0, 16'h0});
    rd_cmp("R12", 16'h0002);

    // R8 hold gating
    chk("R8", "err_hold clear", 32'(err_hold), 0);
    ind_write(16'h1103, 32'h1357_9BDF);
    chk("R8", "err_hold on gated write", 32'(err_hold), 1);
    rd_cmp("R8", 16'h2205);
    chk("R8", "gated read returns zero model", 32'(exp_eh), 1);
    ind_write(16'h100A, 32'h8000_0000);
    chk("R7", "hold bit 1 only", 32'(hold), 32'h2);
    rd_cmp("R8", 16'h1103);
    ind_write(16'h1103, 32'h2468_ACE0);
    rd_cmp("R8", 16'h1103);
    ind_write(16'h100A, 32'h7FFF_FFFF);
    chk("R7", "hold bit cleared", 32'(hold), 32'h0);

    // R9 channel reset length
    bus_wr(3'd2, 16'h2019);
    begin
      int hi = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (chan_rst[2]) hi++;
        if (chan_rst[0] | chan_rst[1] | chan_rst[3]) hi += 100;
      end
      chk("R9", "reset cycles", 32'(hi), 32);
    end
    rd_cmp("R9", 16'h2019);

    // R11 unmapped
    ind_write(16'h5000, 32'hFFFF_FFFF);
    ind_write(16'h001A, 32'hFFFF_FFFF);
    ind_write(16'h0110, 32'hFFFF_FFFF);
    rd_cmp("R11", 16'h5000);
    rd_cmp("R11", 16'h001A);
    rd_cmp("R11", 16'h0110);
    chk("R11", "hold untouched", 32'(hold), 0);
    chk("R11", "err_hold untouched", 32'(err_hold), 32'(exp_eh));

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule